// File: doc/BRIEF.md
# Interrupt Summary and Mask Register Bank

This block gathers nineteen level-sensitive interrupt request lines into three byte-wide registers on a small 8-bit I/O bus. The registers occupy three consecutive byte addresses starting at 0x804. Each request first passes through a two-flop synchronizer. Reading a register returns the synchronized raw request levels, whatever the mask holds. Writing the same address loads the mask byte for those lines. The mask cannot be read back, and a 1 in a mask bit disables its line.

The block gives the processor one registered interrupt output. That output is high while any synchronized request is both raw-active and enabled. A registered lowest-pending-index output with a valid flag names the enabled request that software should service first, since requests are serviced from the lowest index upward.

The request index is also the bit position across the three registers: index 8k+b sits at bit b of the register at base+k. The lines are ordered as follows:

- Indices 0 to 3: line A of slots 0 to 3.
- Index 4: the cascade from the legacy controller.
- Index 5: the disk controller.
- Index 6: USB.
- Index 7: line B of slot 0.
- Indices 8 to 10: line B of slots 1 to 3.
- Indices 11 to 14: line C of slots 0 to 3.
- Index 15: line D of slot 0.
- Indices 16 to 18: line D of slots 1 to 3.

Top module: `irq_summary_bank`

## Requirements
- R1: After reset every mask bit is 1, and irq_out, pend_valid, pend_idx and bus_rdata are 0. With every request held high and no mask write, irq_out stays 0.
- R2: A read strobe at address 0x804+k (k = 0, 1, 2) makes bus_rdata show synchronized request bits 8k to 8k+7 on the following cycle, with index 8k+b at bit b, regardless of the mask. Bits 7:3 at 0x806 read 0. bus_rdata is 0 in any cycle that does not follow a read strobe.
- R3: A write strobe at address 0x804+k loads the mask bits for indices 8k to 8k+7 from bus_wdata bit positions 0 to 7. A 1 disables the line and a 0 enables it. Writes to the reserved bits 7:3 at 0x806 have no effect.
- R4: irq_out is registered and goes high one cycle after a cycle in which any synchronized request is set with its mask bit 0. A mask write first changes irq_out one cycle after the edge that stores it.
- R5: irq_out falls one cycle after the last enabled request clears, or after the last enabled request becomes masked.
- R6: pend_idx is the lowest index whose synchronized request is set and enabled, and pend_valid flags that such an index exists. Both are registered alongside irq_out, and pend_idx is 0 when pend_valid is 0.
- R7: A change on req_in is first seen at irq_out after the third rising edge, because of the two synchronizer flops plus the output register.
- R8: A read below 0x804 or above 0x806 returns 0. A write there leaves the mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_in | input | 19 | Asynchronous level request lines, indexed per the layout |
| bus_addr | input | 12 | Byte address on the I/O bus |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq_out | output | 1 | Combined enabled-request output |
| pend_valid | output | 1 | An enabled request is pending |
| pend_idx | output | 5 | Lowest pending enabled index |

## Verification
The hardest case to reach is proving that the mask takes effect, because the mask is write-only and the only way to observe it is through irq_out and pend_idx. The stimulus writes a mask byte while an enabled request is already high, then samples irq_out in the cycle right after the write edge and again one cycle later. The same approach checks that writes outside the window, and writes to reserved bits, leave the mask unchanged: a line that should stay enabled, or stay masked, is raised afterwards and the index and output are compared.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

  localparam int unsigned DEF_LINES  = 19;
  localparam int unsigned DEF_DATA_W = 8;
  localparam int unsigned DEF_ADDR_W = 12;

  function automatic int unsigned lanes_for(input int unsigned lines, input int unsigned width);
    return (lines + width - 1) / width;
  endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned WIDTH  = 19,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/irq_addr_decode.sv
module irq_addr_decode #(
  parameter int unsigned          ADDR_W    = 12,
  parameter logic [ADDR_W-1:0]    BASE_ADDR = 12'h804,
  parameter int unsigned          NUM_LANES = 3,
  parameter int unsigned          LANE_W    = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [LANE_W-1:0] lane
);

  logic [ADDR_W:0] ext_addr;
  logic [ADDR_W:0] ext_base;
  logic [ADDR_W:0] offset;

  always_comb begin
    ext_addr = {1'b0, addr};
    ext_base = {1'b0, BASE_ADDR};
    offset   = ext_addr - ext_base;
    hit      = (ext_addr >= ext_base) && (offset < (ADDR_W+1)'(NUM_LANES));
    lane     = offset[LANE_W-1:0];
  end

endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
  parameter int unsigned NUM_REQ = 19,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned LANE_W  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [LANE_W-1:0]  lane,
  input  logic [DATA_W-1:0]  wdata,
  output logic [NUM_REQ-1:0] mask
);

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_bit
    localparam int unsigned MY_LANE = g / DATA_W;
    localparam int unsigned MY_POS  = g % DATA_W;
    always_ff @(posedge clk) begin
      if (rst) begin
        mask[g] <= 1'b1;
      end else if (wr_en && (lane == LANE_W'(MY_LANE))) begin
        mask[g] <= wdata[MY_POS];
      end
    end
  end

endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux #(
  parameter int unsigned NUM_REQ   = 19,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned NUM_LANES = 3,
  parameter int unsigned LANE_W    = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_en,
  input  logic [LANE_W-1:0]  lane,
  input  logic [NUM_REQ-1:0] raw,
  output logic [DATA_W-1:0]  rdata
);

  localparam int unsigned PAD_W = NUM_LANES * DATA_W;

  logic [PAD_W-1:0]  raw_pad;
  logic [DATA_W-1:0] sel_byte;

  always_comb begin
    raw_pad              = '0;
    raw_pad[NUM_REQ-1:0] = raw;
    sel_byte             = '0;
    for (int l = 0; l < NUM_LANES; l++) begin
      if (lane == LANE_W'(l)) sel_byte = raw_pad[l*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= sel_byte;
    else            rdata <= '0;
  end

endmodule

// File: rtl/irq_lowest_pend.sv
module irq_lowest_pend #(
  parameter int unsigned NUM_REQ = 19,
  parameter int unsigned IDX_W   = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_REQ-1:0] pend,
  output logic               valid,
  output logic [IDX_W-1:0]   idx
);

  logic [IDX_W-1:0] idx_c;
  logic             any_c;

  always_comb begin
    idx_c = '0;
    any_c = 1'b0;
    for (int i = NUM_REQ - 1; i >= 0; i--) begin
      if (pend[i]) begin
        idx_c = IDX_W'(i);
        any_c = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      idx   <= '0;
    end else begin
      valid <= any_c;
      idx   <= idx_c;
    end
  end

endmodule

// File: rtl/irq_summary_bank.sv
module irq_summary_bank
  import irq_bank_pkg::*;
#(
  parameter int unsigned       NUM_REQ     = DEF_LINES,
  parameter int unsigned       DATA_W      = DEF_DATA_W,
  parameter int unsigned       ADDR_W      = DEF_ADDR_W,
  parameter logic [ADDR_W-1:0] BASE_ADDR   = 12'h804,
  parameter int unsigned       SYNC_STAGES = 2,
  localparam int unsigned      IDX_W       = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_REQ-1:0] req_in,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               irq_out,
  output logic               pend_valid,
  output logic [IDX_W-1:0]   pend_idx
);

  localparam int unsigned NUM_LANES = lanes_for(NUM_REQ, DATA_W);
  localparam int unsigned LANE_W    = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1;

  logic [NUM_REQ-1:0] raw_sync;
  logic [NUM_REQ-1:0] mask_q;
  logic [NUM_REQ-1:0] enabled;
  logic               addr_hit;
  logic [LANE_W-1:0]  addr_lane;

  irq_sync #(.WIDTH(NUM_REQ), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(req_in), .q(raw_sync)
  );

  irq_addr_decode #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .NUM_LANES(NUM_LANES), .LANE_W(LANE_W)
  ) u_dec (
    .addr(bus_addr), .hit(addr_hit), .lane(addr_lane)
  );

  irq_mask_bank #(.NUM_REQ(NUM_REQ), .DATA_W(DATA_W), .LANE_W(LANE_W)) u_mask (
    .clk(clk), .rst(rst), .wr_en(bus_wr && addr_hit), .lane(addr_lane),
    .wdata(bus_wdata), .mask(mask_q)
  );

  irq_read_mux #(
    .NUM_REQ(NUM_REQ), .DATA_W(DATA_W), .NUM_LANES(NUM_LANES), .LANE_W(LANE_W)
  ) u_rd (
    .clk(clk), .rst(rst), .rd_en(bus_rd && addr_hit), .lane(addr_lane),
    .raw(raw_sync), .rdata(bus_rdata)
  );

  assign enabled = raw_sync & ~mask_q;

  irq_lowest_pend #(.NUM_REQ(NUM_REQ), .IDX_W(IDX_W)) u_pend (
    .clk(clk), .rst(rst), .pend(enabled), .valid(pend_valid), .idx(pend_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_out <= 1'b0;
    else     irq_out <= |enabled;
  end

endmodule

module irq_summary_bank_chk #(
  parameter int unsigned NUM_REQ = 19,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned IDX_W   = 5
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_REQ-1:0] raw,
  input logic [NUM_REQ-1:0] mask,
  input logic               irq,
  input logic               pvalid,
  input logic [IDX_W-1:0]   pidx,
  input logic               rd,
  input logic [DATA_W-1:0]  rdata
);

  logic [NUM_REQ-1:0] pend_d;
  logic [NUM_REQ-1:0] below_idx;

  always_ff @(posedge clk) begin
    if (rst) pend_d <= '0;
    else     pend_d <= raw & ~mask;
  end

  always_comb begin
    for (int i = 0; i < NUM_REQ; i++) below_idx[i] = (IDX_W'(i) < pidx);
  end

  a_r1_mask_all_set: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (&mask));

  a_r5_idle_low: assert property (@(posedge clk) disable iff (rst)
    !(|pend_d) |-> !irq);

  a_r6_valid_tracks_irq: assert property (@(posedge clk) disable iff (rst)
    pvalid == irq);

  a_r6_idx_is_pending: assert property (@(posedge clk) disable iff (rst)
    pvalid |-> pend_d[pidx]);

  a_r6_idx_is_lowest: assert property (@(posedge clk) disable iff (rst)
    pvalid |-> ((pend_d & below_idx) == '0));

  a_r2_rdata_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(!rd) |-> (rdata == '0));

endmodule

bind irq_summary_bank irq_summary_bank_chk #(
  .NUM_REQ(NUM_REQ), .DATA_W(DATA_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst(rst), .raw(raw_sync), .mask(mask_q), .irq(irq_out),
  .pvalid(pend_valid), .pidx(pend_idx), .rd(bus_rd), .rdata(bus_rdata)
);

// File: tb/irq_summary_bank_tb.sv
`timescale 1ns/1ps
module irq_summary_bank_tb;

  localparam int unsigned N  = 19;
  localparam logic [11:0] BA = 12'h804;

  typedef struct {
    string      tag;
    logic [7:0] exp;
  } rd_item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [N-1:0] req_in = '0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        irq_out;
  logic        pend_valid;
  logic [4:0]  pend_idx;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;
  logic [N-1:0] req_m = '0;
  rd_item_t rd_q[$];

  always #2 clk = ~clk;

  irq_summary_bank u_dut (
    .clk(clk), .rst(rst), .req_in(req_in), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out),
    .pend_valid(pend_valid), .pend_idx(pend_idx)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input int k);
    logic [23:0] pad;
    pad = {5'b0, req_m};
    if (k < 0 || k > 2) return 8'h00;
    return pad[k*8 +: 8];
  endfunction

  task automatic bus_write(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input string tag, input int k);
    rd_q.push_back('{tag: tag, exp: exp_byte(k)});
    @(negedge clk);
    bus_addr = BA + 12'(k); bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic drive_req(input logic [N-1:0] v);
    @(negedge clk);
    req_in = v; req_m = v;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic check_pend(input string tag, input logic vld, input logic [4:0] idx);
    check({tag, " irq_out"}, 32'(irq_out), 32'(vld));
    check({tag, " pend_valid"}, 32'(pend_valid), 32'(vld));
    check({tag, " pend_idx"}, 32'(pend_idx), 32'(idx));
  endtask

  // monitor: pops the expected read byte for every read strobe it sees
  initial begin
    forever begin
      bit took;
      @(posedge clk);
      took = bus_rd && !rst;
      @(negedge clk);
      if (took) begin
        rd_item_t it;
        if (rd_q.size() == 0) begin
          n_cmp++; n_bad++;
          $display("FAIL R2 unexpected read actual=%0h expected=none", bus_rdata);
        end else begin
          it = rd_q.pop_front();
          check(it.tag, 32'(bus_rdata), 32'(it.exp));
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_pend("R1 reset", 1'b0, 5'd0);
    check("R1 reset rdata", 32'(bus_rdata), 32'h0);

    // all requests high, mask untouched: output must stay low
    drive_req({N{1'b1}});
    settle();
    check_pend("R1 default mask", 1'b0, 5'd0);

    // raw reads ignore the mask; reserved bits read 0
    bus_read("R2 lane0 all", 0);
    bus_read("R2 lane1 all", 1);
    bus_read("R2 lane2 reserved zero", 2);
    bus_read("R8 read above window", 3);
    bus_read("R8 read below window", -1);

    drive_req(19'h2C3A5);
    settle();
    bus_read("R2 lane0 pattern", 0);
    bus_read("R2 lane1 pattern", 1);
    bus_read("R2 lane2 pattern", 2);

    // enable only index 0, then measure synchronizer latency
    drive_req('0);
    settle();
    bus_write(BA, 8'hFE);
    settle();
    check_pend("R3 enabled idle", 1'b0, 5'd0);
    @(negedge clk);
    req_in[0] = 1'b1; req_m[0] = 1'b1;
    @(negedge clk);
    check("R7 after edge1", 32'(irq_out), 32'h0);
    @(negedge clk);
    check("R7 after edge2", 32'(irq_out), 32'h0);
    @(negedge clk);
    check("R7 after edge3", 32'(irq_out), 32'h1);
    check_pend("R6 index0", 1'b1, 5'd0);
    bus_read("R2 raw with mask", 0);

    // mask index 0 again while it is active
    bus_write(BA, 8'hFF);
    check("R4 mask write plus0", 32'(irq_out), 32'h1);
    @(negedge clk);
    check("R5 masked drop", 32'(irq_out), 32'h0);

    // writes outside window must not enable index 0
    bus_write(BA - 12'd1, 8'h00);
    bus_write(BA + 12'd3, 8'h00);
    settle();
    check_pend("R8 outside writes ignored", 1'b0, 5'd0);

    // enable everything; reserved bits written as 1
    bus_write(BA, 8'h00);
    bus_write(BA + 12'd1, 8'h00);
    bus_write(BA + 12'd2, 8'hF8);
    drive_req(19'(1) << 18);
    settle();
    check_pend("R3 lane2 write index18", 1'b1, 5'd18);

    drive_req((19'(1) << 12) | (19'(1) << 4));
    settle();
    check_pend("R6 lowest of 4,12", 1'b1, 5'd4);

    bus_write(BA, 8'h10);
    settle();
    check_pend("R6 masked 4 gives 12", 1'b1, 5'd12);

    drive_req((19'(1) << 7) | (19'(1) << 5));
    settle();
    check_pend("R6 lowest of 5,7", 1'b1, 5'd5);

    drive_req(19'(1) << 4);
    settle();
    check_pend("R3 masked cascade only", 1'b0, 5'd0);

    // last enabled request clears
    drive_req(19'(1) << 9);
    settle();
    check_pend("R6 index9", 1'b1, 5'd9);
    @(negedge clk);
    req_in = '0; req_m = '0;
    @(negedge clk);
    check("R5 clear edge1", 32'(irq_out), 32'h1);
    @(negedge clk);
    check("R5 clear edge2", 32'(irq_out), 32'h1);
    @(negedge clk);
    check("R5 clear edge3", 32'(irq_out), 32'h0);
    check("R6 idx zero when idle", 32'(pend_idx), 32'h0);

    repeat (3) @(negedge clk);
    if (rd_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL R2 pending reads actual=%0d expected=0", rd_q.size());
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule